// File: doc/BRIEF.md
# Electrically Erasable EPROM Mode Controller

This block is a cycle-level behavioural model of a byte-wide, electrically erasable EPROM. Each clock it decodes chip select, output gate, program strobe, the low address bit and two flags: one says the A9 line is at the high identifier/erase voltage, the other says the programming supply is raised. From these inputs it selects one operating mode and either drives the byte bus or leaves it undriven. The storage array is held in on-chip registers. Supply levels, currents and nanosecond timing are not modelled. Strobe widths are counted in clock cycles.

Programming can only clear bits. Only a whole-array erase can set them again. A strobe is accepted only if it is held for a minimum number of cycles. A shorter strobe leaves the array unchanged and raises a sticky error flag. When the identifier voltage is on A9, reads return fixed identifier bytes instead of array data.

Top module: `eprom_ctrl`

## Requirements
- R1: Read mode is chip select low, output gate low, supply not raised and A9 flag low. In that cycle `data_oe_o` is 1 and `data_o` equals the stored byte at `addr_i`.
- R2: While `ce_ni` is high, `data_oe_o` is 0 whatever the other inputs are. A program or erase strobe given in that state leaves the array and `pulse_err_o` unchanged.
- R3: While `ce_ni` is low and `oe_ni` is high, `data_oe_o` is 0. This holds during program and erase strobes as well.
- R4: A program strobe is supply raised, `ce_ni` low, `oe_ni` high and `pgm_ni` low, without the erase combination. When it ends after at least MIN_PULSE cycles, the byte at the address sampled in the strobe's first cycle becomes old AND the data sampled in that cycle. The new value is readable from the next cycle on.
- R5: An erase strobe is a program strobe that also has the A9 flag high and `addr_i[0]` low. When it ends after at least MIN_PULSE cycles, every byte becomes FF hex.
- R6: Identifier mode is `ce_ni` low, `oe_ni` low, A9 flag high and supply not raised. It drives DA hex when `addr_i[0]` is 0 and 01 hex when `addr_i[0]` is 1.
- R7: Verify mode is supply raised, `ce_ni` low, `oe_ni` low and `pgm_ni` high. It drives the stored byte at `addr_i`. With `pgm_ni` low in that state the bus is not driven.
- R8: A program or erase strobe that ends after fewer than MIN_PULSE cycles leaves the array unchanged. It sets `pulse_err_o` on the following edge, and the flag stays set until reset.
- R9: After reset every byte reads FF hex and `pulse_err_o` is 0.
- R10: The array holds 2^ADDR_W bytes, all individually addressable. The default is ADDR_W = 10; the full device size is ADDR_W = 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output gate, active low |
| pgm_ni | input | 1 | Program/erase strobe, active low |
| addr_i | input | ADDR_W | Byte address; bit 0 also selects the identifier byte and qualifies erase |
| a9_hv_i | input | 1 | A9 line at the high identifier/erase voltage |
| vpp_hv_i | input | 1 | Programming supply raised |
| data_i | input | 8 | Byte to program |
| data_o | output | 8 | Byte driven onto the bus |
| data_oe_o | output | 1 | Bus driver enable |
| pulse_err_o | output | 1 | Sticky flag: a strobe was too short |

## Verification
Bus outputs are combinational from the pins and the array. The bench therefore changes pins on the falling edge and samples 2 ns later, in the same cycle. A strobe is committed on the first rising edge that sees it ended, so its effect is due one cycle after the strobe is released. The bench releases the strobe, waits one falling edge, and only then reads back in verify or read mode. The error flag is due on that same edge and is checked at the same point. Strobe lengths of exactly MIN_PULSE and MIN_PULSE-1 cycles are used to bracket the acceptance limit.

// File: rtl/eprom_pkg.sv
`timescale 1ns/1ps
package eprom_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_ERASE} op_e;
  typedef enum logic [2:0] {
    M_STANDBY, M_OUT_OFF, M_READ, M_IDENT, M_VERIFY, M_HV_IDLE, M_PROG, M_ERASE
  } mode_e;
  localparam logic [7:0] ID_MAKER = 8'hDA;
  localparam logic [7:0] ID_PART  = 8'h01;
  localparam logic [7:0] ERASED   = 8'hFF;
endpackage

// File: rtl/eprom_mode_decode.sv
`timescale 1ns/1ps
module eprom_mode_decode
  import eprom_pkg::*;
(
  input  logic  ce_ni,
  input  logic  oe_ni,
  input  logic  pgm_ni,
  input  logic  a0_i,
  input  logic  a9_hv_i,
  input  logic  vpp_hv_i,
  output mode_e mode_o,
  output op_e   op_o
);
  always_comb begin
    if (ce_ni) begin
      mode_o = M_STANDBY;
    end else if (vpp_hv_i) begin
      if (oe_ni) begin
        if (!pgm_ni) mode_o = (a9_hv_i && !a0_i) ? M_ERASE : M_PROG;
        else         mode_o = M_OUT_OFF;
      end else begin
        mode_o = pgm_ni ? M_VERIFY : M_HV_IDLE;
      end
    end else begin
      if (oe_ni)        mode_o = M_OUT_OFF;
      else if (a9_hv_i) mode_o = M_IDENT;
      else              mode_o = M_READ;
    end
  end

  always_comb begin
    case (mode_o)
      M_PROG:  op_o = OP_PROG;
      M_ERASE: op_o = OP_ERASE;
      default: op_o = OP_NONE;
    endcase
  end
endmodule

// File: rtl/eprom_pulse_timer.sv
`timescale 1ns/1ps
module eprom_pulse_timer
  import eprom_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int MIN_PULSE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              commit_prog_o,
  output logic              commit_erase_o,
  output logic              short_pulse_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        data_o
);
  localparam int CNT_W = $clog2(MIN_PULSE + 1);
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_PULSE);

  op_e              kind_q;
  logic [CNT_W-1:0] cnt_q;
  logic             end_pulse, long_enough;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= OP_NONE;
      cnt_q  <= '0;
      addr_o <= '0;
      data_o <= '0;
    end else if (op_i != kind_q) begin
      // new strobe (or none): latch its target on its first cycle
      kind_q <= op_i;
      cnt_q  <= (op_i != OP_NONE) ? CNT_W'(1) : '0;
      addr_o <= addr_i;
      data_o <= data_i;
    end else if (kind_q != OP_NONE && cnt_q < CNT_MIN) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign end_pulse      = (kind_q != OP_NONE) && (op_i != kind_q);
  assign long_enough    = (cnt_q >= CNT_MIN);
  assign commit_prog_o  = end_pulse && long_enough && (kind_q == OP_PROG);
  assign commit_erase_o = end_pulse && long_enough && (kind_q == OP_ERASE);
  assign short_pulse_o  = end_pulse && !long_enough;
endmodule

// File: rtl/eprom_cell_array.sv
`timescale 1ns/1ps
module eprom_cell_array
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= mem_q[wr_addr_i] & wr_data_i; // only 1->0
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/eprom_ctrl.sv
`timescale 1ns/1ps
module eprom_ctrl
  import eprom_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int MIN_PULSE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              pgm_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              a9_hv_i,
  input  logic              vpp_hv_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  output logic              pulse_err_o
);
  mode_e             mode;
  op_e               op;
  logic              commit_prog, commit_erase, short_pulse;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data, rd_data;

  eprom_mode_decode u_decode (
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .pgm_ni   (pgm_ni),
    .a0_i     (addr_i[0]),
    .a9_hv_i  (a9_hv_i),
    .vpp_hv_i (vpp_hv_i),
    .mode_o   (mode),
    .op_o     (op)
  );

  eprom_pulse_timer #(.ADDR_W(ADDR_W), .MIN_PULSE(MIN_PULSE)) u_timer (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .op_i           (op),
    .addr_i         (addr_i),
    .data_i         (data_i),
    .commit_prog_o  (commit_prog),
    .commit_erase_o (commit_erase),
    .short_pulse_o  (short_pulse),
    .addr_o         (wr_addr),
    .data_o         (wr_data)
  );

  eprom_cell_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (commit_prog),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .erase_i   (commit_erase),
    .rd_addr_i (addr_i),
    .rd_data_o (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pulse_err_o <= 1'b0;
    else if (short_pulse) pulse_err_o <= 1'b1;
  end

  always_comb begin
    data_o    = 8'h00;
    data_oe_o = 1'b0;
    case (mode)
      M_READ, M_VERIFY: begin
        data_o    = rd_data;
        data_oe_o = 1'b1;
      end
      M_IDENT: begin
        data_o    = addr_i[0] ? ID_PART : ID_MAKER;
        data_oe_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/eprom_ctrl_chk.sv
`timescale 1ns/1ps
module eprom_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_ni,
  input logic       oe_ni,
  input logic       pgm_ni,
  input logic       a0_i,
  input logic       a9_hv_i,
  input logic       vpp_hv_i,
  input logic [7:0] data_o,
  input logic       data_oe_o,
  input logic       pulse_err_o,
  input logic       short_pulse_i
);
  AST_STANDBY_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !data_oe_o); // R2
  AST_GATE_HIGH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && oe_ni) |-> !data_oe_o); // R3
  AST_READ_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && !vpp_hv_i && !a9_hv_i) |-> data_oe_o); // R1
  AST_ID_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && a9_hv_i && !vpp_hv_i)
      |-> (data_oe_o && data_o == (a0_i ? 8'h01 : 8'hDA))); // R6
  AST_VERIFY_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && vpp_hv_i) |-> (data_oe_o == pgm_ni)); // R7
  AST_SHORT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_pulse_i |=> pulse_err_o); // R8
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_err_o |=> pulse_err_o); // R8
endmodule

bind eprom_ctrl eprom_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ce_ni         (ce_ni),
  .oe_ni         (oe_ni),
  .pgm_ni        (pgm_ni),
  .a0_i          (addr_i[0]),
  .a9_hv_i       (a9_hv_i),
  .vpp_hv_i      (vpp_hv_i),
  .data_o        (data_o),
  .data_oe_o     (data_oe_o),
  .pulse_err_o   (pulse_err_o),
  .short_pulse_i (short_pulse)
);

// File: tb/eprom_ctrl_test.sv
`timescale 1ns/1ps
module eprom_ctrl_test;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;
  localparam int MINP  = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ce_ni = 1'b1, oe_ni = 1'b1, pgm_ni = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          a9_hv = 1'b0, vpp_hv = 1'b0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          dout_en, perr;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [DEPTH];

  always #5 clk = ~clk;

  eprom_ctrl #(.ADDR_W(AW), .MIN_PULSE(MINP)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni), .pgm_ni(pgm_ni),
    .addr_i(addr), .a9_hv_i(a9_hv), .vpp_hv_i(vpp_hv), .data_i(din),
    .data_o(dout), .data_oe_o(dout_en), .pulse_err_o(perr)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic pins(input logic ce, input logic oe, input logic pg, input logic [AW-1:0] a,
                      input logic a9, input logic vpp, input logic [7:0] d);
    @(negedge clk);
    ce_ni = ce; oe_ni = oe; pgm_ni = pg; addr = a; a9_hv = a9; vpp_hv = vpp; din = d;
    #2;
  endtask

  // strobe of n sampled cycles, then released; commit lands on the next edge
  task automatic strobe(input logic ce, input logic [AW-1:0] a, input logic a9,
                        input logic [7:0] d, input int n);
    @(negedge clk);
    ce_ni = ce; oe_ni = 1'b1; pgm_ni = 1'b0; addr = a; a9_hv = a9; vpp_hv = 1'b1; din = d;
    repeat (n) @(negedge clk);
    pgm_ni = 1'b1;
    @(negedge clk);
    ce_ni = 1'b1; vpp_hv = 1'b0; a9_hv = 1'b0;
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;

    // R9 reset state, R10 every address reachable
    pins(1, 1, 1, 0, 0, 0, 0);
    check("R9 err", {7'd0, perr}, 8'h00);
    for (int i = 0; i < DEPTH; i++) begin
      pins(0, 0, 1, AW'(i), 0, 0, 0);
      check("R9 R10 read", dout, 8'hFF);
      if (i == 0) check("R1 oe", {7'd0, dout_en}, 8'h01);
    end

    // R3 output gate high, R2 standby
    pins(0, 1, 1, 3, 0, 0, 0);
    check("R3 oe", {7'd0, dout_en}, 8'h00);
    pins(0, 1, 0, 3, 0, 0, 0);
    check("R3 oe pgm low", {7'd0, dout_en}, 8'h00);
    pins(1, 0, 1, 3, 0, 0, 0);
    check("R2 oe", {7'd0, dout_en}, 8'h00);
    pins(1, 0, 0, 3, 1, 1, 0);
    check("R2 oe hv", {7'd0, dout_en}, 8'h00);

    // R6 identifier
    pins(0, 0, 1, 0, 1, 0, 0);
    check("R6 maker", dout, 8'hDA);
    pins(0, 0, 1, 1, 1, 0, 0);
    check("R6 part", dout, 8'h01);

    // R4 two program passes over the whole array, bits only clear
    for (int i = 0; i < DEPTH; i++) begin
      logic [7:0] d1;
      d1 = 8'(i) ^ 8'(i >> 2) ^ 8'h5A;
      strobe(0, AW'(i), 0, d1, MINP);
      model[i] = model[i] & d1;
    end
    for (int i = 0; i < DEPTH; i++) begin
      logic [7:0] d2;
      d2 = ~8'(i * 3);
      strobe(0, AW'(i), 0, d2, MINP);
      model[i] = model[i] & d2;
    end
    for (int i = 0; i < DEPTH; i++) begin
      pins(0, 0, 1, AW'(i), 0, 1, 0);
      check("R4 R7 verify", dout, model[i]);
      pins(0, 0, 1, AW'(i), 0, 0, 0);
      check("R4 R1 read", dout, model[i]);
    end
    pins(0, 0, 0, 9, 0, 1, 0);
    check("R7 strobe low undriven", {7'd0, dout_en}, 8'h00);
    pins(0, 1, 0, 9, 0, 0, 0);
    check("R3 during strobe", {7'd0, dout_en}, 8'h00);
    pins(1, 1, 1, 9, 0, 0, 0);

    // R2 deselected strobe ignored
    strobe(1, 5, 0, 8'h00, MINP + 2);
    pins(0, 0, 1, 5, 0, 0, 0);
    check("R2 array", dout, model[5]);
    check("R2 err", {7'd0, perr}, 8'h00);

    // R8 short program
    strobe(0, 7, 0, 8'h00, MINP - 1);
    pins(0, 0, 1, 7, 0, 0, 0);
    check("R8 array", dout, model[7]);
    check("R8 err set", {7'd0, perr}, 8'h01);

    // R8 short erase, flag stays set after a good program
    strobe(0, 0, 1, 8'hFF, MINP - 1);
    pins(0, 0, 1, 2, 0, 0, 0);
    check("R8 erase short", dout, model[2]);
    strobe(0, 11, 0, 8'h00, MINP);
    model[11] = 8'h00;
    pins(0, 0, 1, 11, 0, 0, 0);
    check("R4 clear all", dout, 8'h00);
    check("R8 sticky", {7'd0, perr}, 8'h01);

    // R5 full erase
    strobe(0, 0, 1, 8'hFF, MINP);
    for (int i = 0; i < DEPTH; i++) begin
      pins(0, 0, 1, AW'(i), 0, 0, 0);
      check("R5 erased", dout, 8'hFF);
    end

    // R9 reset clears flag and array
    strobe(0, 20, 0, 8'h00, MINP);
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    pins(0, 0, 1, 20, 0, 0, 0);
    check("R9 re-reset byte", dout, 8'hFF);
    check("R9 re-reset err", {7'd0, perr}, 8'h00);

    finish_run();
  end
endmodule